// File: doc/BRIEF.md
# Chip-Select Wait-State Sequencer

This block runs external bus cycles for ten chip-select areas, numbered 0 to 9. Each area has a four-bit configuration nibble. The nibble holds a bus-mode bit, which picks protocol A or protocol B, and a three-bit wait code. The nibbles are packed two to a byte in five byte registers, and these sit behind a simple register write and read port. A requester raises `req` together with an area index. While the sequencer is idle it accepts the request and latches that area's effective settings. It then drives the area's one-hot chip select through three phases: an address/strobe cycle, a wait phase, and a single completion cycle.

A wait code from 0 to 6 inserts that many fixed wait cycles. Code 7 selects handshake timing, where the wait phase ends once `ready` is sampled high. If `ready` stays low past a programmable timeout, the access ends with an error pulse instead of a completion pulse. Protocol B needs at least two wait cycles. A protocol-B area programmed with code 0 or 1 is clamped to two waits, and the clamp sets a sticky error flag. Area 0 is fixed to protocol A and area 9 is fixed to protocol B, whatever is written to their mode bits.

The controller has five states:
- IDLE: waiting for a request.
- ADDR: the strobe cycle.
- WAIT: the wait phase.
- DONE: the completion pulse.
- FAIL: the timeout error pulse.

Its transitions are:
- accept: IDLE to ADDR, on a valid request.
- skip: ADDR to DONE, for fixed zero waits.
- stretch: ADDR to WAIT.
- count-out: WAIT to DONE, when the fixed count is reached.
- ready-seen: WAIT to DONE, in handshake timing.
- timeout: WAIT to FAIL.
- release: DONE or FAIL back to IDLE.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset, registers 0 to 3 read 0x66 and register 4 reads 0xE6. The flag register (address 5) reads 0x00.
- R2: Register r (0 to 4) holds area 2r in bits 3:0 and area 2r+1 in bits 7:4. Within each nibble, the top bit is the mode (0 = protocol A, 1 = protocol B) and the low three bits are the wait code. Written values read back this way.
- R3: Register 0 bit 3 always reads 0 and register 4 bit 7 always reads 1, whatever is written. Accesses to area 0 show `bus_mode`=0 and accesses to area 9 show `bus_mode`=1.
- R4: With fixed wait code k, `addr_stb` is high only in the first cycle after acceptance. `done` is high in cycle k+2 after acceptance, counting the first cycle after the accepting edge as cycle 1.
- R5: During an access only the addressed area's `cs` bit is high, from the strobe cycle through the final cycle. Outside accesses all `cs` bits are low.
- R6: A protocol-B access with wait code 0 or 1 runs with exactly two waits and sets `cfg_err`. The flag stays set until a write to address 5 with bit 0 = 1.
- R7: With wait code 7, `done` comes in the cycle after the first wait cycle in which `ready` is sampled high.
- R8: In handshake timing, if `ready` stays low for TIMEOUT wait cycles, `err` pulses in cycle TIMEOUT+2 and `done` does not pulse.
- R9: Requests are ignored while an access is in progress, and requests with an area index of 10 or more are ignored.
- R10: A register write during an access does not change that access. It takes effect from the next access.
- R11: `done` and `err` each last exactly one cycle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0-4 config, 5 flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cfg_err | output | 1 | Sticky clamp flag |
| req | input | 1 | Access request |
| req_area | input | 4 | Area index of the request |
| ready | input | 1 | External ready for handshake timing |
| cs | output | 10 | One-hot chip selects, active high |
| addr_stb | output | 1 | Address/strobe cycle |
| bus_mode | output | 1 | Protocol of the active access (1 = B) |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Handshake timeout pulse |

## Verification
The bench sweeps every area through every fixed code under both mode settings and measures the cycle of the completion pulse against arithmetic expectations. An off-by-one wait counter would shift `done` by one cycle, and a missing clamp would let a protocol-B area finish in fewer than two waits. It also drives `ready` on the first wait cycle, in the middle of the wait phase and on the very last cycle before timeout, and lets the timeout expire. A design that gave the timeout priority over `ready` would raise `err` where `done` is expected. Finally, it injects a second request and a register rewrite in the middle of an access, and writes to the locked mode bits. A design that re-latched its settings or honoured those bits would change the chip select, the cycle count or the reported protocol.

// File: rtl/cswait_pkg.sv
package cswait_pkg;
    localparam int NUM_AREAS = 10;
    localparam int NUM_REGS  = NUM_AREAS / 2;
    localparam int FLAG_REG  = NUM_REGS;

    typedef logic [2:0] wcode_t;
    localparam wcode_t CODE_HS    = 3'b111;
    localparam wcode_t CODE_RST   = 3'b110;
    localparam wcode_t MIN_WAIT_B = 3'd2;

    typedef struct packed {
        logic   mode_b;
        wcode_t code;
    } area_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_DONE,
        S_FAIL
    } bus_state_t;
endpackage

// File: rtl/cswait_regs.sv
module cswait_regs
    import cswait_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              err_set,
    output area_cfg_t         cfg [NUM_AREAS],
    output logic              cfg_err
);
    logic [NUM_AREAS-1:0] mode_w;
    logic                 flag_clr;

    assign flag_clr = we && (addr == REG_AW'(FLAG_REG)) && wdata[0];

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
        localparam int RIDX = a / 2;
        localparam int LSB  = (a % 2) * 4;
        wcode_t code_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                code_q <= CODE_RST;
            else if (we && addr == REG_AW'(RIDX))
                code_q <= wdata[LSB +: 3];
        end

        if (a == 0) begin : g_lock_a
            assign mode_w[a] = 1'b0;
        end else if (a == NUM_AREAS - 1) begin : g_lock_b
            assign mode_w[a] = 1'b1;
        end else begin : g_free
            logic mode_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mode_q <= 1'b0;
                else if (we && addr == REG_AW'(RIDX))
                    mode_q <= wdata[LSB + 3];
            end
            assign mode_w[a] = mode_q;
        end

        assign cfg[a] = {mode_w[a], code_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (err_set)
            cfg_err <= 1'b1;
        else if (flag_clr)
            cfg_err <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == REG_AW'(r))
                rdata = {cfg[2*r+1], cfg[2*r]};
        end
        if (addr == REG_AW'(FLAG_REG))
            rdata = {7'b0, cfg_err};
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !flag_clr) |=> cfg_err); // R6
endmodule

// File: rtl/cswait_resolve.sv
module cswait_resolve
    import cswait_pkg::*;
(
    input  area_cfg_t cfg,
    output logic      mode_b,
    output logic      hs,
    output wcode_t    nwait,
    output logic      clamp
);
    assign mode_b = cfg.mode_b;
    assign hs     = (cfg.code == CODE_HS);
    assign clamp  = cfg.mode_b && (cfg.code < MIN_WAIT_B);
    assign nwait  = clamp ? MIN_WAIT_B : cfg.code;
endmodule

// File: rtl/cswait_seq.sv
module cswait_seq
    import cswait_pkg::*;
#(
    parameter int TIMEOUT = 256,
    parameter int AREA_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [AREA_W-1:0]    req_area,
    input  logic                 sel_ok,
    input  logic                 mode_b,
    input  logic                 hs,
    input  wcode_t               nwait,
    input  logic                 clamp,
    input  logic                 ready,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 addr_stb,
    output logic                 bus_mode,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 clamp_evt
);
    localparam int CNT_W = (TIMEOUT > 8) ? $clog2(TIMEOUT) : 3;

    bus_state_t        state_q, state_d;
    logic [AREA_W-1:0] area_q;
    logic              mode_q, hs_q;
    wcode_t            nwait_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept;

    assign accept    = (state_q == S_IDLE) && req && sel_ok;
    assign clamp_evt = accept && clamp;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_ADDR;
            S_ADDR: state_d = (hs_q || nwait_q != '0) ? S_WAIT : S_DONE;
            S_WAIT: begin
                if (hs_q) begin
                    if (ready)
                        state_d = S_DONE;
                    else if (cnt_q == CNT_W'(TIMEOUT - 1))
                        state_d = S_FAIL;
                end else if (cnt_q == CNT_W'(nwait_q - 3'd1)) begin
                    state_d = S_DONE;
                end
            end
            S_DONE: state_d = S_IDLE;
            S_FAIL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            area_q  <= '0;
            mode_q  <= 1'b0;
            hs_q    <= 1'b0;
            nwait_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                area_q  <= req_area;
                mode_q  <= mode_b;
                hs_q    <= hs;
                nwait_q <= nwait;
            end
            if (state_q == S_ADDR)
                cnt_q <= '0;
            else if (state_q == S_WAIT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        addr_stb = (state_q == S_ADDR);
        done     = (state_q == S_DONE);
        err      = (state_q == S_FAIL);
        bus_mode = busy && mode_q;
    end

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cs
        assign cs[a] = busy && (area_q == AREA_W'(a));
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs)); // R5
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs)); // R5
    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs == '0)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R11
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R11
    AST_MODEB_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && bus_mode) |=> (state_q == S_WAIT)); // R6
    AST_ERR_HS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> hs_q); // R8
    AST_AREA0_MODE_A: assert property (@(posedge clk) disable iff (!rst_n)
        cs[0] |-> !bus_mode); // R3
    AST_AREA9_MODE_B: assert property (@(posedge clk) disable iff (!rst_n)
        cs[NUM_AREAS-1] |-> bus_mode); // R3
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !err) |=> $stable(area_q)); // R9
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
    import cswait_pkg::*;
#(
    parameter int TIMEOUT = 256,
    parameter int REG_AW  = 3,
    parameter int AREA_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 cfg_err,
    input  logic                 req,
    input  logic [AREA_W-1:0]    req_area,
    input  logic                 ready,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 addr_stb,
    output logic                 bus_mode,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    area_cfg_t cfg [NUM_AREAS];
    area_cfg_t cfg_sel;
    logic      sel_ok, mode_b, hs, clamp, clamp_evt;
    wcode_t    nwait;

    assign sel_ok = (req_area < AREA_W'(NUM_AREAS));

    always_comb begin
        cfg_sel = cfg[0];
        for (int a = 0; a < NUM_AREAS; a++) begin
            if (req_area == AREA_W'(a))
                cfg_sel = cfg[a];
        end
    end

    cswait_regs #(.REG_AW(REG_AW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .err_set (clamp_evt),
        .cfg     (cfg),
        .cfg_err (cfg_err)
    );

    cswait_resolve i_resolve (
        .cfg    (cfg_sel),
        .mode_b (mode_b),
        .hs     (hs),
        .nwait  (nwait),
        .clamp  (clamp)
    );

    cswait_seq #(.TIMEOUT(TIMEOUT), .AREA_W(AREA_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_area  (req_area),
        .sel_ok    (sel_ok),
        .mode_b    (mode_b),
        .hs        (hs),
        .nwait     (nwait),
        .clamp     (clamp),
        .ready     (ready),
        .cs        (cs),
        .addr_stb  (addr_stb),
        .bus_mode  (bus_mode),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .clamp_evt (clamp_evt)
    );
endmodule

// File: tb/test_cs_wait_ctrl.sv
module test_cs_wait_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 12;

    logic       clk = 0, rst_n = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       cfg_err, req = 0, ready = 0;
    logic [3:0] req_area = 0;
    logic [9:0] cs;
    logic       addr_stb, bus_mode, busy, done, err;

    int errors = 0, checks = 0;
    logic [7:0] sh [5];

    cs_wait_ctrl #(.TIMEOUT(TMO)) i_cs_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_err(cfg_err),
        .req(req), .req_area(req_area), .ready(ready), .cs(cs),
        .addr_stb(addr_stb), .bus_mode(bus_mode), .busy(busy),
        .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int r, input logic [7:0] d);
        if (r == 0) return d & 8'hF7;
        if (r == 4) return d | 8'h80;
        return d;
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a < 5) sh[a] = d;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic set_nib(input int area, input logic [3:0] nib);
        logic [7:0] v;
        v = sh[area/2];
        if (area % 2) v[7:4] = nib; else v[3:0] = nib;
        wr(area/2, v);
    endtask

    task automatic run_access(input int area, input int ready_at, input int intr,
                              input bit mid_wr, input logic [7:0] mid_data,
                              output int end_idx, output bit fin_done,
                              output bit cs_ok, output bit mode_seen);
        @(negedge clk);
        req = 1; req_area = 4'(area);
        cs_ok = 1; end_idx = 0; fin_done = 0; mode_seen = 0;
        for (int idx = 1; idx < 200; idx++) begin
            @(negedge clk);
            if (idx == 1) begin
                req = (intr >= 0);
                if (intr >= 0) req_area = 4'(intr);
                mode_seen = bus_mode;
                if (!addr_stb) cs_ok = 0;
                if (mid_wr) begin
                    reg_we = 1; reg_addr = 3'(area/2); reg_wdata = mid_data;
                end
            end else begin
                if (addr_stb) cs_ok = 0;
                reg_we = 0;
            end
            if (idx == ready_at) ready = 1;
            if (cs != 10'(1 << area)) cs_ok = 0;
            if (done && err) cs_ok = 0;
            if (done || err) begin
                fin_done = done; end_idx = idx;
                break;
            end
        end
        req = 0; ready = 0; reg_we = 0;
        if (mid_wr) sh[area/2] = mid_data;
        @(negedge clk);
        if (cs != 0 || busy || done || err) cs_ok = 0;
    endtask

    initial begin
        logic [7:0] d;
        int ei; bit fd, ok, ms;
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int r = 0; r < 5; r++) begin
            rd(r, d);
            chk(d == (r == 4 ? 8'hE6 : 8'h66), "R1 reset value", d, r == 4 ? 8'hE6 : 8'h66);
            sh[r] = (r == 4) ? 8'hE6 : 8'h66;
        end
        rd(5, d);
        chk(d == 8'h00, "R1 flag reset", d, 0);
        chk(cs == 0 && !busy && !done && !err, "R5 idle outputs", cs, 0);

        // R2 / R3 register packing and locked bits
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 5; r++) begin
                wr(r, pats[p]);
                rd(r, d);
                chk(d == exp_rd(r, pats[p]), (r == 0 || r == 4) ? "R3 locked bit" : "R2 readback",
                    d, exp_rd(r, pats[p]));
            end

        // R4 / R6 / R3 sweep: every area, both mode bits, every fixed code
        for (int area = 0; area < 10; area++)
            for (int m = 0; m < 2; m++)
                for (int code = 0; code < 7; code++) begin
                    int me, wt;
                    set_nib(area, 4'({m[0], code[2:0]}));
                    me = (area == 0) ? 0 : (area == 9) ? 1 : m;
                    wt = (me == 1 && code < 2) ? 2 : code;
                    run_access(area, -1, -1, 0, 8'h0, ei, fd, ok, ms);
                    chk(fd && ei == wt + 2, (me == 1 && code < 2) ? "R6 clamp timing" : "R4 wait timing",
                        ei, wt + 2);
                    chk(ok, "R5 chip select", ok, 1);
                    chk(ms == me[0], "R3 bus mode", ms, me);
                end

        // R6 sticky flag
        rd(5, d);
        chk(d == 8'h01, "R6 flag set", d, 1);
        wr(5, 8'h00);
        rd(5, d);
        chk(d == 8'h01, "R6 flag kept", d, 1);
        wr(5, 8'h01);
        rd(5, d);
        chk(d == 8'h00, "R6 flag cleared", d, 0);
        set_nib(3, 4'b0011);
        run_access(3, -1, -1, 0, 8'h0, ei, fd, ok, ms);
        rd(5, d);
        chk(d == 8'h00, "R6 no clamp no flag", d, 0);

        // R7 handshake: ready at different points
        for (int t = 0; t < 2; t++) begin
            int area;
            area = t ? 9 : 4;
            set_nib(area, 4'b0111);
            for (int k = 0; k < 5; k++) begin
                int ra, ex;
                ra = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : (k == 3) ? 9 : TMO + 1;
                ex = ((ra > 2) ? ra : 2) + 1;
                run_access(area, ra, -1, 0, 8'h0, ei, fd, ok, ms);
                chk(fd && ei == ex, "R7 handshake done", ei, ex);
                chk(ok, "R11 pulse shape", ok, 1);
            end
            // R8 timeout
            run_access(area, -1, -1, 0, 8'h0, ei, fd, ok, ms);
            chk(!fd && ei == TMO + 2, "R8 timeout err", ei, TMO + 2);
            chk(ok, "R11 err pulse", ok, 1);
        end

        // R9 request while busy ignored
        set_nib(3, 4'b0100);
        run_access(3, -1, 5, 0, 8'h0, ei, fd, ok, ms);
        chk(fd && ei == 6 && ok, "R9 busy request ignored", ei, 6);

        // R9 invalid area ignored
        for (int a = 10; a < 16; a++) begin
            @(negedge clk);
            req = 1; req_area = 4'(a);
            @(negedge clk);
            req = 0;
            chk(!busy && cs == 0, "R9 invalid area", busy, 0);
        end

        // R10 mid-access write
        set_nib(5, 4'b0101);
        run_access(5, -1, -1, 1, {4'b0001, sh[2][3:0]}, ei, fd, ok, ms);
        chk(fd && ei == 7 && ok, "R10 old config kept", ei, 7);
        run_access(5, -1, -1, 0, 8'h0, ei, fd, ok, ms);
        chk(fd && ei == 3 && ok, "R10 new config used", ei, 3);

        summary();
    end
endmodule